// File: doc/BRIEF.md
# Four-Channel Compare Timer with Watchdog Reset

This block is a memory-mapped timer for an operating system's tick and timeout needs. A 32-bit up-counter advances by one on every clock cycle in which the tick-enable input is high. Four compare registers are checked against the counter's next value. When a compare matches and its channel is enabled, a sticky status bit sets. That bit drives the channel's interrupt line until software clears it by writing a one to it.

The last compare channel has a second role as a one-shot watchdog. When bit 0 of the watchdog-arm register is set and that channel matches, the block sends a one-cycle system-reset request. In the same cycle it clears the arm register. The watchdog acts whether or not that channel's interrupt is enabled.

Software reaches the block through a simple single-cycle register port. Reads are combinational and are valid while select is high and write is low. Writes take effect at the clock edge.

Top module: `match_timer`

## Requirements
- R1: After reset the counter, the interrupt-enable register, the watchdog-arm register and the status register all read 0, every interrupt output is low and the reset request is low.
- R2: The counter increments by one on each clock cycle with tick-enable high and holds otherwise. It wraps from 0xFFFFFFFF to 0.
- R3: If tick-enable is high and the counter plus one equals compare register n, channel n matches. If interrupt-enable bit n is 1, status bit n and interrupt output n are high from the following cycle. The counter is not cleared by a match.
- R4: A channel whose interrupt-enable bit is 0 never sets its status bit or raises its interrupt output.
- R5: A write to the status register (offset 0x14) clears each status bit n for which write-data bit n is 1. Bits written as 0 are unaffected. A match in the same cycle wins and leaves the bit set.
- R6: When watchdog-arm bit 0 is 1 and channel 3 matches, the reset request is high for exactly one cycle. From that cycle the watchdog-arm register (offset 0x18) reads 0.
- R7: With watchdog-arm bit 0 equal to 0, a channel 3 match never raises the reset request.
- R8: A write to the counter (offset 0x10) loads the written value, and counting resumes from it. The load itself causes no match, and no tick is applied in that cycle.
- R9: The interrupt-enable register (offset 0x1C) keeps write-data bits 11:0. It reads back with bits 31:12 equal to 0. Bits 3:0 enable channels 0 to 3.
- R10: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 or 0x1C returns 0. No read changes any state.
- R11: Compare register n is at offset 4*n for n = 0 to 3 and reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Counter advances on cycles where this is high |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data; combinational; 0 when not reading |
| irqOut | output | 4 | Per-channel interrupt, equal to the status bits |
| sysResetReq | output | 1 | One-cycle system reset request from the watchdog |

## Verification
Read data is due in the same cycle as the request. The bench checks it one time unit after it drives the inputs on the falling edge. Interrupt lines and the reset request are due one edge after the ticking cycle that matches. A status write or register write is due at the edge that ends its cycle. The bench updates its own model at each rising edge and compares all outputs one time unit later. Directed sequences aim ticks and status clears at the same cycle, and they load the counter with a compare value. Random traffic keeps compare values a few ticks ahead of the counter so that matches and watchdog trips are frequent.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int ADDR_W   = 8;
  localparam int NUM_CH   = 4;
  localparam int CH_IDX_W = $clog2(NUM_CH);

  localparam logic [ADDR_W-1:0] OFF_CMP0   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_WDOG   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 8'h1C;

  typedef enum logic [2:0] {
    RD_NONE, RD_CMP, RD_COUNT, RD_STATUS, RD_WDOG, RD_IEN
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0]   wrCmp;
    logic                wrCount;
    logic                wrStatus;
    logic                wrWdog;
    logic                wrIen;
    rdSel_e              rdSel;
    logic [CH_IDX_W-1:0] rdIdx;
  } strobe_t;
endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  logic              cmpHit;
  logic [CH_IDX_W-1:0] cmpIdx;

  // compare registers sit on consecutive words from OFF_CMP0
  always_comb begin
    cmpHit = 1'b0;
    cmpIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == OFF_CMP0 + ADDR_W'(4 * i)) begin
        cmpHit = 1'b1;
        cmpIdx = CH_IDX_W'(i);
      end
    end
  end

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (busSel) begin
      if (cmpHit) begin
        if (busWr) strb.wrCmp[cmpIdx] = 1'b1;
        else begin
          strb.rdSel = RD_CMP;
          strb.rdIdx = cmpIdx;
        end
      end else begin
        case (busAddr)
          OFF_COUNT:  if (busWr) strb.wrCount  = 1'b1; else strb.rdSel = RD_COUNT;
          OFF_STATUS: if (busWr) strb.wrStatus = 1'b1; else strb.rdSel = RD_STATUS;
          OFF_WDOG:   if (busWr) strb.wrWdog   = 1'b1; else strb.rdSel = RD_WDOG;
          OFF_IEN:    if (busWr) strb.wrIen    = 1'b1; else strb.rdSel = RD_IEN;
          default:    strb.rdSel = RD_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mtimer_dpath.sv
module mtimer_dpath
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int IEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  strobe_t           strb,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [NUM_CH-1:0] irqOut,
  output logic              sysResetReq
);
  localparam int LAST_CH = NUM_CH - 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cntNext;
  logic [CNT_W-1:0]  cmpReg [NUM_CH];
  logic [NUM_CH-1:0] fire;
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] clrMask;
  logic [IEN_W-1:0]  ien;
  logic [CNT_W-1:0]  wdog;
  logic              wdTrip;
  logic              rstReq;
  logic              pastValid;

  assign cntNext = cnt + CNT_W'(1);

  // counter: a load wins over a tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (strb.wrCount)  cnt <= wdata;
    else if (tickEn)        cnt <= cntNext;
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gCh
      assign fire[g] = tickEn && !strb.wrCount && (cntNext == cmpReg[g]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cmpReg[g] <= '0;
        else if (strb.wrCmp[g]) cmpReg[g] <= wdata;
      end

      p_status_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pastValid && $rose(status[g])) |-> $past(ien[g]));

      p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pastValid && $past(strb.wrStatus && wdata[g] && !fire[g])) |-> !status[g]);
    end
  endgenerate

  assign clrMask = strb.wrStatus ? wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clrMask) | (fire & ien[NUM_CH-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ien <= '0;
    else if (strb.wrIen) ien <= wdata[IEN_W-1:0];
  end

  // watchdog: a trip disarms and overrides a same-cycle write
  assign wdTrip = fire[LAST_CH] && wdog[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdog   <= '0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= wdTrip;
      if (wdTrip)           wdog <= '0;
      else if (strb.wrWdog) wdog <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  always_comb begin
    case (strb.rdSel)
      RD_CMP:    rdata = cmpReg[strb.rdIdx];
      RD_COUNT:  rdata = cnt;
      RD_STATUS: rdata = CNT_W'(status);
      RD_WDOG:   rdata = wdog;
      RD_IEN:    rdata = CNT_W'(ien);
      default:   rdata = '0;
    endcase
  end

  assign irqOut      = status;
  assign sysResetReq = rstReq;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(tickEn && !strb.wrCount)) |-> cnt == $past(cnt) + CNT_W'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $past(!tickEn && !strb.wrCount)) |-> $stable(cnt));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sysResetReq |=> !sysResetReq);

  p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sysResetReq |-> wdog == '0);

  p_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && $rose(sysResetReq)) |-> $past(wdog[0]));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int IEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [NUM_CH-1:0] irqOut,
  output logic              sysResetReq
);
  strobe_t strb;

  mtimer_ctrl u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  mtimer_dpath #(.CNT_W(CNT_W), .IEN_W(IEN_W)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .tickEn      (tickEn),
    .strb        (strb),
    .wdata       (busWdata),
    .rdata       (busRdata),
    .irqOut      (irqOut),
    .sysResetReq (sysResetReq)
  );
endmodule

// File: tb/sim_match_timer.sv
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  irqOut;
  logic        sysResetReq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [31:0] mCnt;
  logic [31:0] mCmp [4];
  logic [3:0]  mStatus;
  logic [11:0] mIen;
  logic [31:0] mWd;
  logic        mRst;

  always #10 clk = ~clk;

  match_timer u0 (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .sysResetReq(sysResetReq)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C: return mCmp[a[3:2]];
      8'h10: return mCnt;
      8'h14: return {28'b0, mStatus};
      8'h18: return mWd;
      8'h1C: return {20'b0, mIen};
      default: return 32'b0;
    endcase
  endfunction

  task automatic modelStep(input logic tk, input logic wr, input logic [7:0] a, input logic [31:0] d);
    logic [3:0] fr;
    logic       ldCnt;
    ldCnt = wr && (a == 8'h10);
    for (int i = 0; i < 4; i++) fr[i] = tk && !ldCnt && (mCnt + 32'd1 == mCmp[i]);
    mRst = fr[3] && mWd[0];
    if (wr && a == 8'h14) mStatus = mStatus & ~d[3:0];
    mStatus = mStatus | (fr & mIen[3:0]);
    if (mRst) mWd = 32'b0;
    else if (wr && a == 8'h18) mWd = d;
    if (wr && a == 8'h1C) mIen = d[11:0];
    if (wr && (a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C)) mCmp[a[3:2]] = d;
    if (ldCnt) mCnt = d;
    else if (tk) mCnt = mCnt + 32'd1;
  endtask

  task automatic doCycle(input logic tk, input logic sel, input logic wr,
                         input logic [7:0] a, input logic [31:0] d, input string rq);
    @(negedge clk);
    tickEn = tk; busSel = sel; busWr = wr; busAddr = a; busWdata = d;
    #1;
    if (sel && !wr) check(rq, busRdata, modelRead(a));
    @(posedge clk);
    modelStep(tk, sel && wr, a, d);
    #1;
    check("R3 irq", {28'b0, irqOut}, {28'b0, mStatus});
    check("R6 rstreq", {31'b0, sysResetReq}, {31'b0, mRst});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    doCycle(1'b0, 1'b1, 1'b1, a, d, "");
  endtask
  task automatic rd(input logic [7:0] a, input string rq);
    doCycle(1'b0, 1'b1, 1'b0, a, 32'b0, rq);
  endtask
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) doCycle(1'b1, 1'b0, 1'b0, 8'h00, 32'b0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    mCnt = 0; mStatus = 0; mIen = 0; mWd = 0; mRst = 0;
    for (int i = 0; i < 4; i++) mCmp[i] = 0;
    void'($urandom(32'd24681357));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {28'b0, irqOut}, 32'b0);
    check("R1 rstreq", {31'b0, sysResetReq}, 32'b0);
    rd(8'h10, "R1 count");
    rd(8'h1C, "R1 ien");
    rd(8'h18, "R1 wdog");
    rd(8'h14, "R1 status");

    // R11 compare register map
    wr(8'h00, 32'h1111_0000); wr(8'h04, 32'h2222_0001);
    wr(8'h08, 32'h3333_0002); wr(8'h0C, 32'h4444_0003);
    rd(8'h00, "R11 cmp0"); rd(8'h04, "R11 cmp1");
    rd(8'h08, "R11 cmp2"); rd(8'h0C, "R11 cmp3");

    // R9 enable width
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, "R9 ien");
    wr(8'h1C, 32'h0000_0005);

    // R3/R4: channel 0 enabled, channel 1 disabled, same compare value
    wr(8'h10, 32'd100); wr(8'h00, 32'd103); wr(8'h04, 32'd103);
    tick(3);
    check("R3 irq0", {31'b0, irqOut[0]}, 32'd1);
    check("R4 irq1", {31'b0, irqOut[1]}, 32'd0);
    rd(8'h14, "R4 status");
    tick(2);
    rd(8'h10, "R3 count runs on");

    // R5 write-one-to-clear
    wr(8'h14, 32'h0000_0002);
    check("R5 zero-effect", {31'b0, irqOut[0]}, 32'd1);
    wr(8'h14, 32'h0000_0001);
    check("R5 cleared", {31'b0, irqOut[0]}, 32'd0);
    wr(8'h10, 32'd204); wr(8'h00, 32'd205);
    doCycle(1'b1, 1'b1, 1'b1, 8'h14, 32'h1, "");
    check("R5 set wins", {31'b0, irqOut[0]}, 32'd1);
    wr(8'h14, 32'hF);

    // R8 load equal to a compare value does not match
    wr(8'h08, 32'd500);
    wr(8'h10, 32'd500);
    check("R8 no match on load", {31'b0, irqOut[2]}, 32'd0);
    tick(1);
    rd(8'h10, "R8 resumes");

    // R2 wrap
    wr(8'h10, 32'hFFFF_FFFF);
    tick(1);
    rd(8'h10, "R2 wrap");
    doCycle(1'b0, 1'b0, 1'b0, 8'h00, 32'b0, "");
    rd(8'h10, "R2 hold");

    // R6 watchdog trip, channel 3 interrupt disabled
    wr(8'h10, 32'd1000); wr(8'h0C, 32'd1002); wr(8'h18, 32'd1);
    tick(2);
    check("R6 pulse", {31'b0, sysResetReq}, 32'd1);
    check("R4 irq3", {31'b0, irqOut[3]}, 32'd0);
    tick(1);
    check("R6 one cycle", {31'b0, sysResetReq}, 32'd0);
    rd(8'h18, "R6 disarmed");

    // R7 unarmed
    wr(8'h10, 32'd1001);
    tick(1);
    check("R7 no reset", {31'b0, sysResetReq}, 32'd0);

    // R10 unmapped reads
    rd(8'h24, "R10 unmapped");
    rd(8'h40, "R10 unmapped");
    rd(8'hFC, "R10 unmapped");
    rd(8'h10, "R10 no side effect");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int unsigned op;
      logic [7:0]  a;
      logic [31:0] d;
      op = $urandom % 10;
      if (op < 5) tick(1);
      else if (op == 5) begin
        a = 8'(($urandom % 4) * 4);
        d = mCnt + 32'($urandom % 6) + 32'd1;
        doCycle(1'($urandom), 1'b1, 1'b1, a, d, "");
      end else if (op == 6) begin
        case ($urandom % 4)
          0: doCycle(1'($urandom), 1'b1, 1'b1, 8'h10, 32'($urandom % 4) - 32'd2, "");
          1: doCycle(1'($urandom), 1'b1, 1'b1, 8'h18, 32'($urandom % 2), "");
          2: doCycle(1'($urandom), 1'b1, 1'b1, 8'h1C, $urandom, "");
          default: doCycle(1'($urandom), 1'b1, 1'b1, 8'h14, $urandom, "");
        endcase
      end else begin
        a = 8'(($urandom % 12) * 4);
        doCycle(1'($urandom), 1'b1, 1'b0, a, 32'b0, "R11 R10 random read");
      end
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule